// File: doc/BRIEF.md
# Program Exception Cause Detector

This block sits beside the execute stage and examines every instruction as it issues. It compares the instruction against the processor status, the floating-point status and the two trap operands. It then decides whether the instruction has to raise a program exception, which is handled at vector 0x700. When an exception is raised, the block reports exactly one cause bit for the machine-state save register. There are four causes: an illegal instruction, a supervisor-only instruction attempted in user mode, a trap whose selected comparison holds, and a pending floating-point exception that is enabled.

The decoder is only as deep as these four checks need. It classifies the primary opcode and, under the extended primary opcode 31, the ten-bit extended opcode. It also looks at the most significant bit of the ten-bit special-register number used by the move-to and move-from special-register forms. The verdict is registered, so the request and the cause vector appear one clock after the instruction is sampled.

Top module: `pxc_top`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first instruction is sampled, `excReq` is 0 and `causeVec` is 0.
- R2: Outputs are registered. The verdict for an instruction sampled at a rising edge with `exValid`=1 appears after that edge. A cycle sampled with `exValid`=0 gives `excReq`=0 and `causeVec`=0 whatever the other inputs are.
- R3: The floating-point cause, bit 0 of `causeVec`, is raised when (`fpMode0` or `fpMode1`) is 1 and `fpSummary` is 1. It is not raised when either half of that condition is 0.
- R4: The illegal cause, bit 1, is raised for the primary opcodes 0, 1, 2, 4, 5, 6, 9, 22, 30, 56, 57, 58, 60, 61 and 62. Any other primary opcode is not illegal on its own.
- R5: With primary opcode 31, an extended opcode of 600 or more is illegal, except code 854. Every listed special code is legal: 4, 83, 146, 306, 339, 370 (when implemented), 467 and 470. Other codes below 600 are legal. With any other primary opcode, `extOp` is ignored.
- R6: The optional extended code 370 is illegal when the parameter `OPT_IMPLEMENTED` is 0. The optional code 854 is handled as a no-op and is never illegal.
- R7: The privileged cause, bit 2, is raised for the supervisor-only extended codes 83, 146, 306 and 470 when `probState`=1. These codes raise nothing when `probState`=0.
- R8: The special-register moves are extended codes 339 (read) and 467 (write). They raise the privileged cause when `sprNum[9]`=1 and `probState`=1. They raise nothing when either of those is 0.
- R9: The trap cause, bit 3, applies to primary opcode 3 and to extended code 4. It is raised when any enabled condition holds. The enable bits are `trapTo[4]` for signed A<B, `trapTo[3]` for signed A>B, `trapTo[2]` for A==B, `trapTo[1]` for unsigned A<B and `trapTo[0]` for unsigned A>B.
- R10: When several causes apply, only the highest is reported. The order from highest is illegal, privileged, trap, floating-point. `causeVec` is zero or one-hot, and `excReq` is 1 exactly when `causeVec` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exValid | input | 1 | An instruction is at execute this cycle |
| primOp | input | 6 | Primary opcode |
| extOp | input | 10 | Extended opcode, used under primary opcode 31 |
| sprNum | input | 10 | Special-register number field |
| probState | input | 1 | 1 = user (problem) state |
| fpMode0 | input | 1 | Floating-point exception mode bit 0 |
| fpMode1 | input | 1 | Floating-point exception mode bit 1 |
| fpSummary | input | 1 | Floating-point enabled-exception summary bit |
| trapTo | input | 5 | Trap condition enables |
| trapA | input | DATA_W | First trap operand |
| trapB | input | DATA_W | Second trap operand |
| excReq | output | 1 | Program exception request |
| causeVec | output | 4 | One-hot cause: bit0 fp, bit1 illegal, bit2 privileged, bit3 trap |

## Verification
The bench builds the block with `DATA_W`=8 and `OPT_IMPLEMENTED`=0. The narrow operand width brings the points where signed and unsigned order disagree (0x7F against 0x80, 0x00 against 0xFF) within reach of the trap comparisons. Keeping the optional code unimplemented lets the bench exercise the illegal path for code 370 alongside the no-op code 854. A pseudo-random sweep over all fields then piles up overlapping causes to test the priority order.

// File: rtl/pxc_pkg.sv
package pxc_pkg;

  localparam int PRIM_W  = 6;
  localparam int EXT_W   = 10;
  localparam int SPR_W   = 10;
  localparam int TO_W    = 5;
  localparam int CAUSE_W = 4;

  // Cause bit positions in the saved machine-state word
  localparam int CAUSE_FP      = 0;
  localparam int CAUSE_ILLEGAL = 1;
  localparam int CAUSE_PRIV    = 2;
  localparam int CAUSE_TRAP    = 3;

  // Trap condition enable positions
  localparam int TO_UGT = 0;
  localparam int TO_ULT = 1;
  localparam int TO_EQ  = 2;
  localparam int TO_SGT = 3;
  localparam int TO_SLT = 4;

  // Primary opcodes
  localparam logic [PRIM_W-1:0] PRIM_TRAP_IMM = 6'd3;
  localparam logic [PRIM_W-1:0] PRIM_EXTENDED = 6'd31;
  // One bit per primary opcode; set = reserved/illegal
  localparam logic [63:0] PRIM_ILLEGAL_MASK = 64'h7700_0000_4040_0277;

  // Extended opcodes under PRIM_EXTENDED
  localparam logic [EXT_W-1:0] EXT_TRAP     = 10'd4;
  localparam logic [EXT_W-1:0] EXT_SUPV_A   = 10'd83;
  localparam logic [EXT_W-1:0] EXT_SUPV_B   = 10'd146;
  localparam logic [EXT_W-1:0] EXT_SUPV_C   = 10'd306;
  localparam logic [EXT_W-1:0] EXT_SPR_RD   = 10'd339;
  localparam logic [EXT_W-1:0] EXT_OPTIONAL = 10'd370;
  localparam logic [EXT_W-1:0] EXT_SPR_WR   = 10'd467;
  localparam logic [EXT_W-1:0] EXT_SUPV_D   = 10'd470;
  localparam logic [EXT_W-1:0] EXT_OPT_NOP  = 10'd854;

  typedef enum logic [2:0] {
    EXT_PLAIN,
    EXT_BAD,
    EXT_SUPV,
    EXT_SPRMOVE,
    EXT_TRAPOP
  } extClass_t;

  typedef struct packed {
    logic valid;
    logic illegal;
    logic priv;
    logic sprAccess;
    logic trap;
  } ctlStrobes_t;

endpackage

// File: rtl/pxc_control.sv
module pxc_control
  import pxc_pkg::*;
#(
  parameter bit OPT_IMPLEMENTED = 1'b0,
  parameter int EXT_LEGAL_LIMIT = 600
) (
  input  logic              exValid,
  input  logic [PRIM_W-1:0] primOp,
  input  logic [EXT_W-1:0]  extOp,
  output ctlStrobes_t       strb
);

  extClass_t extClass;
  logic      isExtended;
  logic      primIllegal;

  assign isExtended  = (primOp == PRIM_EXTENDED);
  assign primIllegal = PRIM_ILLEGAL_MASK[primOp];

  // Classify the extended opcode (R5, R6, R7, R8, R9)
  always_comb begin
    unique case (extOp)
      EXT_TRAP:                           extClass = EXT_TRAPOP;
      EXT_SUPV_A, EXT_SUPV_B,
      EXT_SUPV_C, EXT_SUPV_D:             extClass = EXT_SUPV;
      EXT_SPR_RD, EXT_SPR_WR:             extClass = EXT_SPRMOVE;
      EXT_OPTIONAL:                       extClass = OPT_IMPLEMENTED ? EXT_PLAIN : EXT_BAD;
      EXT_OPT_NOP:                        extClass = EXT_PLAIN;
      default: extClass = (int'(extOp) >= EXT_LEGAL_LIMIT) ? EXT_BAD : EXT_PLAIN;
    endcase
  end

  always_comb begin
    strb.valid     = exValid;
    strb.illegal   = primIllegal || (isExtended && extClass == EXT_BAD);
    strb.priv      = isExtended && extClass == EXT_SUPV;
    strb.sprAccess = isExtended && extClass == EXT_SPRMOVE;
    strb.trap      = (primOp == PRIM_TRAP_IMM) || (isExtended && extClass == EXT_TRAPOP);
  end

endmodule

// File: rtl/pxc_datapath.sv
module pxc_datapath
  import pxc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctlStrobes_t        strb,
  input  logic               sprMsb,
  input  logic               probState,
  input  logic               fpMode0,
  input  logic               fpMode1,
  input  logic               fpSummary,
  input  logic [TO_W-1:0]    trapTo,
  input  logic [DATA_W-1:0]  trapA,
  input  logic [DATA_W-1:0]  trapB,
  output logic               excReq,
  output logic [CAUSE_W-1:0] causeVec
);

  logic [TO_W-1:0]    condMet;
  logic               trapHit;
  logic               privHit;
  logic               fpHit;
  logic [CAUSE_W-1:0] nextCause;

  // One comparator per trap condition enable (R9)
  generate
    for (genvar g = 0; g < TO_W; g++) begin : g_cond
      if (g == TO_SLT) begin : g_slt
        assign condMet[g] = $signed(trapA) < $signed(trapB);
      end else if (g == TO_SGT) begin : g_sgt
        assign condMet[g] = $signed(trapA) > $signed(trapB);
      end else if (g == TO_EQ) begin : g_eq
        assign condMet[g] = trapA == trapB;
      end else if (g == TO_ULT) begin : g_ult
        assign condMet[g] = trapA < trapB;
      end else begin : g_ugt
        assign condMet[g] = trapA > trapB;
      end
    end
  endgenerate

  assign trapHit = strb.trap && |(condMet & trapTo);
  assign privHit = probState && (strb.priv || (strb.sprAccess && sprMsb));
  assign fpHit   = (fpMode0 || fpMode1) && fpSummary;

  // Priority: illegal > privileged > trap > floating-point (R10)
  always_comb begin
    nextCause = '0;
    if (strb.valid) begin
      if (strb.illegal)  nextCause[CAUSE_ILLEGAL] = 1'b1;
      else if (privHit)  nextCause[CAUSE_PRIV]    = 1'b1;
      else if (trapHit)  nextCause[CAUSE_TRAP]    = 1'b1;
      else if (fpHit)    nextCause[CAUSE_FP]      = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      causeVec <= '0;
      excReq   <= 1'b0;
    end else begin
      causeVec <= nextCause;
      excReq   <= |nextCause;
    end
  end

  assert_onehot_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(causeVec) && (excReq == (causeVec != '0)));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(strb.valid)) |-> (!excReq && causeVec == '0));

  assert_illegal_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(strb.valid) && $past(strb.illegal))
      |-> (causeVec == CAUSE_W'(1 << CAUSE_ILLEGAL)));

  assert_priv_user_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && causeVec[CAUSE_PRIV]) |-> $past(probState));

  assert_fp_needs_summary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && causeVec[CAUSE_FP]) |-> ($past(fpSummary) && ($past(fpMode0) || $past(fpMode1))));

  assert_trap_from_trap_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && causeVec[CAUSE_TRAP]) |-> ($past(strb.trap) && $past(trapTo) != '0));

endmodule

// File: rtl/pxc_top.sv
module pxc_top
  import pxc_pkg::*;
#(
  parameter int DATA_W          = 32,
  parameter bit OPT_IMPLEMENTED = 1'b0,
  parameter int EXT_LEGAL_LIMIT = 600
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exValid,
  input  logic [PRIM_W-1:0]  primOp,
  input  logic [EXT_W-1:0]   extOp,
  input  logic [SPR_W-1:0]   sprNum,
  input  logic               probState,
  input  logic               fpMode0,
  input  logic               fpMode1,
  input  logic               fpSummary,
  input  logic [TO_W-1:0]    trapTo,
  input  logic [DATA_W-1:0]  trapA,
  input  logic [DATA_W-1:0]  trapB,
  output logic               excReq,
  output logic [CAUSE_W-1:0] causeVec
);

  ctlStrobes_t strb;

  pxc_control #(
    .OPT_IMPLEMENTED(OPT_IMPLEMENTED),
    .EXT_LEGAL_LIMIT(EXT_LEGAL_LIMIT)
  ) i_control (
    .exValid(exValid),
    .primOp (primOp),
    .extOp  (extOp),
    .strb   (strb)
  );

  pxc_datapath #(
    .DATA_W(DATA_W)
  ) i_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .sprMsb   (sprNum[SPR_W-1]),
    .probState(probState),
    .fpMode0  (fpMode0),
    .fpMode1  (fpMode1),
    .fpSummary(fpSummary),
    .trapTo   (trapTo),
    .trapA    (trapA),
    .trapB    (trapB),
    .excReq   (excReq),
    .causeVec (causeVec)
  );

endmodule

// File: tb/test_pxc_top.sv
module test_pxc_top;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          exValid = 1'b0;
  logic [5:0]    primOp = '0;
  logic [9:0]    extOp = '0;
  logic [9:0]    sprNum = '0;
  logic          probState = 1'b0;
  logic          fpMode0 = 1'b0;
  logic          fpMode1 = 1'b0;
  logic          fpSummary = 1'b0;
  logic [4:0]    trapTo = '0;
  logic [DW-1:0] trapA = '0;
  logic [DW-1:0] trapB = '0;
  logic          excReq;
  logic [3:0]    causeVec;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;
  int  illegalPrim[$] = '{0, 1, 2, 4, 5, 6, 9, 22, 30, 56, 57, 58, 60, 61, 62};

  always #(CLK_PERIOD/2) clk = ~clk;

  pxc_top #(.DATA_W(DW), .OPT_IMPLEMENTED(1'b0), .EXT_LEGAL_LIMIT(600)) i_pxc_top (
    .clk(clk), .rst_n(rst_n), .exValid(exValid), .primOp(primOp), .extOp(extOp),
    .sprNum(sprNum), .probState(probState), .fpMode0(fpMode0), .fpMode1(fpMode1),
    .fpSummary(fpSummary), .trapTo(trapTo), .trapA(trapA), .trapB(trapB),
    .excReq(excReq), .causeVec(causeVec)
  );

  // Behavioural reference: returns expected cause vector for current inputs
  function automatic logic [3:0] refModel();
    bit ill = 0, prv = 0, trp = 0, fpe = 0;
    int sa, sb, ua, ub, e;
    if (!exValid) return 4'b0000;
    foreach (illegalPrim[k]) if (int'(primOp) == illegalPrim[k]) ill = 1;
    e = int'(extOp);
    if (primOp == 6'd31) begin
      if (e == 370) ill = 1;
      else if (e >= 600 && e != 854) ill = 1;
      if ((e == 83 || e == 146 || e == 306 || e == 470) && probState) prv = 1;
      if ((e == 339 || e == 467) && sprNum[9] && probState) prv = 1;
    end
    if (primOp == 6'd3 || (primOp == 6'd31 && e == 4)) begin
      sa = int'($signed(trapA)); sb = int'($signed(trapB));
      ua = int'(trapA);          ub = int'(trapB);
      if (trapTo[4] && sa < sb) trp = 1;
      if (trapTo[3] && sa > sb) trp = 1;
      if (trapTo[2] && ua == ub) trp = 1;
      if (trapTo[1] && ua < ub) trp = 1;
      if (trapTo[0] && ua > ub) trp = 1;
    end
    fpe = (fpMode0 || fpMode1) && fpSummary;
    if (ill) return 4'b0010;
    if (prv) return 4'b0100;
    if (trp) return 4'b1000;
    if (fpe) return 4'b0001;
    return 4'b0000;
  endfunction

  task automatic compare(input string tag, input logic [3:0] exp);
    checks++;
    if (causeVec !== exp || excReq !== (exp != 4'b0)) begin
      fails++;
      $display("FAIL %s: causeVec=%b excReq=%b expected causeVec=%b excReq=%b",
               tag, causeVec, excReq, exp, (exp != 4'b0));
    end
  endtask

  task automatic clear();
    exValid = 1; primOp = 6'd14; extOp = '0; sprNum = '0; probState = 0;
    fpMode0 = 0; fpMode1 = 0; fpSummary = 0; trapTo = '0; trapA = '0; trapB = '0;
  endtask

  // Inputs are set by the caller after a negedge; result checked after next posedge
  task automatic step(input string tag);
    logic [3:0] exp;
    exp = refModel();
    @(posedge clk); #1;
    compare(tag, exp);
    @(negedge clk);
  endtask

  task automatic setTrap(input logic [5:0] p, input logic [9:0] e, input logic [4:0] to,
                         input logic [DW-1:0] a, input logic [DW-1:0] b);
    clear(); primOp = p; extOp = e; trapTo = to; trapA = a; trapB = b;
  endtask

  initial begin
    logic [31:0] lcg;
    @(negedge clk);
    // R1: reset state
    clear(); primOp = 6'd0; fpMode0 = 1; fpSummary = 1;
    repeat (3) begin @(posedge clk); #1; compare("R1", 4'b0000); @(negedge clk); end
    rst_n = 1; exValid = 0;
    @(posedge clk); #1; compare("R1", 4'b0000); @(negedge clk);

    // R2: invalid cycles are ignored
    clear(); exValid = 0; primOp = 6'd0; fpMode1 = 1; fpSummary = 1; step("R2");
    clear(); step("R2");

    // R3: fp enabled combinations
    for (int m = 0; m < 8; m++) begin
      clear(); fpMode0 = m[0]; fpMode1 = m[1]; fpSummary = m[2]; step("R3");
    end

    // R4: every primary opcode
    for (int p = 0; p < 64; p++) begin
      clear(); primOp = 6'(p); extOp = 10'd100; step("R4");
    end

    // R5: extended legality boundaries, extOp ignored elsewhere
    foreach (illegalPrim[k]) begin end
    begin
      int codes[] = '{0, 4, 83, 146, 306, 339, 467, 470, 599, 600, 601, 853, 855, 1023};
      foreach (codes[k]) begin clear(); primOp = 6'd31; extOp = 10'(codes[k]); step("R5"); end
      clear(); primOp = 6'd14; extOp = 10'd1023; step("R5");
    end

    // R6: optional codes
    clear(); primOp = 6'd31; extOp = 10'd370; step("R6");
    clear(); primOp = 6'd31; extOp = 10'd854; step("R6");
    clear(); primOp = 6'd31; extOp = 10'd854; probState = 1; step("R6");

    // R7: supervisor-only codes
    begin
      int sup[] = '{83, 146, 306, 470};
      foreach (sup[k]) for (int u = 0; u < 2; u++) begin
        clear(); primOp = 6'd31; extOp = 10'(sup[k]); probState = u[0]; step("R7");
      end
    end

    // R8: special-register moves
    for (int v = 0; v < 8; v++) begin
      clear(); primOp = 6'd31; extOp = v[0] ? 10'd467 : 10'd339;
      sprNum = v[1] ? 10'h200 : 10'h1FF; probState = v[2]; step("R8");
    end

    // R9: each enable across signed/unsigned disagreement points
    begin
      logic [DW-1:0] pa[] = '{8'h80, 8'h01, 8'h05, 8'h7F, 8'h00, 8'h03};
      logic [DW-1:0] pb[] = '{8'h01, 8'h80, 8'h05, 8'h80, 8'hFF, 8'h07};
      foreach (pa[k]) for (int t = 0; t < 5; t++) begin
        setTrap(6'd3, 10'd0, 5'(1 << t), pa[k], pb[k]); step("R9");
        setTrap(6'd31, 10'd4, 5'(1 << t), pa[k], pb[k]); step("R9");
      end
      setTrap(6'd3, 10'd0, 5'b00000, 8'h01, 8'h02); step("R9");
      setTrap(6'd14, 10'd4, 5'b11111, 8'h01, 8'h02); step("R9");
    end

    // R10: overlapping causes
    clear(); primOp = 6'd0; fpMode0 = 1; fpSummary = 1; step("R10");
    clear(); primOp = 6'd31; extOp = 10'd700; probState = 1; fpMode0 = 1; fpSummary = 1; step("R10");
    clear(); primOp = 6'd31; extOp = 10'd146; probState = 1; fpMode1 = 1; fpSummary = 1; step("R10");
    setTrap(6'd3, 10'd0, 5'b00100, 8'h09, 8'h09); fpMode0 = 1; fpSummary = 1; step("R10");
    setTrap(6'd3, 10'd0, 5'b00100, 8'h09, 8'h08); fpMode0 = 1; fpSummary = 1; step("R10");

    // R10: pseudo-random sweep biased toward interesting opcodes
    lcg = 32'h1234_5678;
    for (int i = 0; i < 3000; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      exValid = lcg[31] | lcg[30];
      case (lcg[29:28])
        2'd0: primOp = 6'd31;
        2'd1: primOp = 6'd3;
        default: primOp = lcg[27:22];
      endcase
      case (lcg[21:19])
        3'd0: extOp = 10'd4;   3'd1: extOp = 10'd339; 3'd2: extOp = 10'd467;
        3'd3: extOp = 10'd146; 3'd4: extOp = 10'd370; 3'd5: extOp = 10'd854;
        default: extOp = lcg[17:8];
      endcase
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      sprNum = lcg[31:22]; probState = lcg[21]; fpMode0 = lcg[20]; fpMode1 = lcg[19];
      fpSummary = lcg[18]; trapTo = lcg[17:13]; trapA = lcg[12:5]; trapB = {lcg[4:0], lcg[31:29]};
      step("R10");
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule